// File: doc/BRIEF.md
# Received-Word Host Reader with Repeater Path

This block holds one received 32-bit serial-bus word at a time and lets a host read it over a 16-bit bus as two halves. A half-select input picks the half, and an active-low read strobe places it on the bus. An active-low data-ready output tells the host that a word is waiting. The flag clears once both halves of the word have been read, and the next buffered word is then accepted from the receive buffer through a valid/ready handshake.

When repeater mode is enabled in the control register, each read also feeds the transmit path. A lower-half read stages that half. The matching upper-half read then writes the whole word into an 8-deep transmit FIFO, so the word can be sent again without the host writing it back. When the parity option is on, the top bit of the queued word is replaced by odd parity over the other 31 bits. If the upper half is read first in repeater mode, the host still gets the data, but nothing is queued and a sticky sequence-error flag is raised.

A master reset clears the held word, the staging state, the FIFO and all flags. It leaves the control register untouched. Only the power-on reset sets the control register back to zero.

Top module: `a429_repeat_if`

## Requirements
- R1: After power-on reset, dready_n and rx_ready are 1, tx_empty is 1, tx_level is 0, seq_err, tx_ovf, ctrl_rpt and ctrl_par are 0.
- R2: When rx_valid and rx_ready are both high at a clock edge, the word is captured. From then on dready_n is 0 and rx_ready is 0 until the word has been consumed.
- R3: While rd_en_n is low, host_dout carries word bits 15:0 when half_sel is 0 and bits 31:16 when half_sel is 1. While rd_en_n is high, host_dout is 0.
- R4: A read strobe is the cycle in which rd_en_n is first seen low. In normal mode, either half may be read first. dready_n stays 0 after the first strobe and goes to 1 after the strobe that completes the second half. No word enters the FIFO.
- R5: In repeater mode, a lower-half strobe followed by an upper-half strobe queues exactly one FIFO entry. With parity off, that entry equals the received word.
- R6: With ctrl_par set, bit 31 of the queued word is the odd parity of bits 30:0, meaning the 32-bit result has an odd number of ones. Bits 30:0 are unchanged.
- R7: In repeater mode, an upper-half strobe with no lower half staged queues nothing and sets seq_err. seq_err stays set until a reset.
- R8: The FIFO holds 8 words and returns them in write order on tx_head. A tx_pop removes the head. tx_full is 1 exactly when 8 words are held.
- R9: A completed word written while tx_full is 1 is dropped, sets the sticky tx_ovf flag, and leaves the contents and level unchanged.
- R10: A master reset (mrst_n low for a clock edge) empties the FIFO, drops the held word (dready_n goes to 1), and clears seq_err and tx_ovf. ctrl_rpt and ctrl_par keep their values.
- R11: The first cycle in which cw_wr_n is seen low loads ctrl_din bit 0 into ctrl_rpt (repeater enable) and bit 1 into ctrl_par (parity enable).
- R12: A read strobe while dready_n is 1 has no effect: nothing is queued, seq_err is not set, and dready_n stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low; clears everything including control |
| mrst_n | input | 1 | Synchronous master reset, active low; control register kept |
| rx_valid | input | 1 | Receive buffer has a word |
| rx_word | input | 32 | Word from the receive buffer |
| rx_ready | output | 1 | Block accepts a word this cycle |
| dready_n | output | 1 | Active-low word-available flag |
| half_sel | input | 1 | 0 selects bits 15:0, 1 selects bits 31:16 |
| rd_en_n | input | 1 | Active-low read enable / strobe |
| host_dout | output | 16 | Host data bus (read half) |
| cw_wr_n | input | 1 | Active-low control-write strobe |
| ctrl_din | input | 2 | Control value: bit 0 repeater, bit 1 parity |
| ctrl_rpt | output | 1 | Repeater mode enabled |
| ctrl_par | output | 1 | Parity insertion enabled |
| tx_pop | input | 1 | Transmitter takes the FIFO head |
| tx_head | output | 32 | Oldest queued word |
| tx_empty | output | 1 | FIFO empty |
| tx_full | output | 1 | FIFO full |
| tx_level | output | 4 | Number of queued words |
| seq_err | output | 1 | Sticky: upper half read before lower in repeater mode |
| tx_ovf | output | 1 | Sticky: completed word dropped on a full FIFO |

## Verification
Sixteen words are swept through all four combinations of the repeater and parity bits, with both read orders. The words include all-zero, all-one and multiplicative-hash patterns, so the two halves and both parity values are clearly distinct. Each order and mode combination separates a different path: lower-first repeater reads must queue exactly one correctly filled word, upper-first repeater reads must queue nothing and flag an error, and normal-mode reads must never touch the FIFO. A separate fill with nine distinct words tells FIFO ordering apart from the overflow drop. A master reset applied while a word is held and words are queued shows what is cleared and what the control register keeps.

// File: rtl/a429_rpt_pkg.sv
package a429_rpt_pkg;
   // Control register image; bit positions follow ctrl_din.
   typedef struct packed {
      logic par_en;   // bit 1
      logic rpt_en;   // bit 0
   } ctrl_t;

   typedef enum logic {
      HALF_LO = 1'b0,
      HALF_HI = 1'b1
   } half_e;
endpackage

// File: rtl/a429_fall_strobe.sv
// Single-cycle strobe on the first sampled low cycle of an active-low level.
module a429_fall_strobe (
   input  logic clk,
   input  logic por_n,
   input  logic lvl_n,
   output logic strobe
);
   logic lvl_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) lvl_q <= 1'b1;
      else        lvl_q <= lvl_n;
   end

   assign strobe = lvl_q & ~lvl_n;
endmodule

// File: rtl/a429_rx_hold.sv
// Holds one received word, tracks which halves were read, drives the bus.
module a429_rx_hold #(
   parameter int unsigned WORD_W = 32,
   parameter int unsigned BUS_W  = 16
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              mrst_n,
   input  logic              rx_valid,
   input  logic [WORD_W-1:0] rx_word,
   output logic              rx_ready,
   input  logic              rd_stb,
   input  logic              rd_en_n,
   input  logic              half_sel,
   output logic [BUS_W-1:0]  host_dout,
   output logic              held,
   output logic              rd_ok,
   output logic              word_load,
   output logic [WORD_W-1:0] hold_word
);
   import a429_rpt_pkg::*;

   logic got_lo, got_hi;
   logic nxt_lo, nxt_hi;

   assign rx_ready  = ~held & mrst_n;
   assign word_load = rx_valid & rx_ready;
   assign rd_ok     = rd_stb & held;
   assign nxt_lo    = got_lo | (half_sel == HALF_LO);
   assign nxt_hi    = got_hi | (half_sel == HALF_HI);

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         held      <= 1'b0;
         got_lo    <= 1'b0;
         got_hi    <= 1'b0;
         hold_word <= '0;
      end else if (!mrst_n) begin
         held   <= 1'b0;
         got_lo <= 1'b0;
         got_hi <= 1'b0;
      end else if (word_load) begin
         hold_word <= rx_word;
         held      <= 1'b1;
         got_lo    <= 1'b0;
         got_hi    <= 1'b0;
      end else if (rd_ok) begin
         if (nxt_lo && nxt_hi) begin
            held   <= 1'b0;
            got_lo <= 1'b0;
            got_hi <= 1'b0;
         end else begin
            got_lo <= nxt_lo;
            got_hi <= nxt_hi;
         end
      end
   end

   always_comb begin
      if (rd_en_n)                 host_dout = '0;
      else if (half_sel == HALF_HI) host_dout = hold_word[WORD_W-1:BUS_W];
      else                         host_dout = hold_word[BUS_W-1:0];
   end
endmodule

// File: rtl/a429_repeat_seq.sv
// Repeater sequencing: stages the lower half, assembles and fills parity.
module a429_repeat_seq #(
   parameter int unsigned WORD_W  = 32,
   parameter int unsigned BUS_W   = 16,
   parameter bit          ODD_PAR = 1'b1
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              mrst_n,
   input  logic              rpt_en,
   input  logic              par_en,
   input  logic              rd_ok,
   input  logic              half_sel,
   input  logic              word_load,
   input  logic [WORD_W-1:0] hold_word,
   output logic              push,
   output logic [WORD_W-1:0] push_word,
   output logic              seq_err
);
   import a429_rpt_pkg::*;

   logic [BUS_W-1:0]  stage_lo;
   logic              stage_vld;
   logic [WORD_W-1:0] raw_word;
   logic              par_bit;
   logic              rd_lo, rd_hi;

   assign rd_lo = rd_ok & rpt_en & (half_sel == HALF_LO);
   assign rd_hi = rd_ok & rpt_en & (half_sel == HALF_HI);
   assign push  = rd_hi & stage_vld;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         stage_lo  <= '0;
         stage_vld <= 1'b0;
         seq_err   <= 1'b0;
      end else if (!mrst_n) begin
         stage_vld <= 1'b0;
         seq_err   <= 1'b0;
      end else begin
         if (word_load) begin
            stage_vld <= 1'b0;
         end else if (rd_lo) begin
            stage_lo  <= hold_word[BUS_W-1:0];
            stage_vld <= 1'b1;
         end else if (rd_hi) begin
            stage_vld <= 1'b0;
         end
         if (rd_hi && !stage_vld) seq_err <= 1'b1;
      end
   end

   assign raw_word = {hold_word[WORD_W-1:BUS_W], stage_lo};

   generate
      if (ODD_PAR) begin : g_odd
         assign par_bit = ~(^raw_word[WORD_W-2:0]);
      end else begin : g_even
         assign par_bit = ^raw_word[WORD_W-2:0];
      end
   endgenerate

   assign push_word = par_en ? {par_bit, raw_word[WORD_W-2:0]} : raw_word;
endmodule

// File: rtl/a429_tx_fifo.sv
// Word FIFO toward the transmitter with drop-on-full and sticky overflow.
module a429_tx_fifo #(
   parameter int unsigned WORD_W = 32,
   parameter int unsigned DEPTH  = 8,
   localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              mrst_n,
   input  logic              push,
   input  logic [WORD_W-1:0] push_data,
   input  logic              pop,
   output logic [WORD_W-1:0] head,
   output logic              empty,
   output logic              full,
   output logic [CNT_W-1:0]  level,
   output logic              ovf
);
   logic [WORD_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic              do_push, do_pop;

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap
         assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   assign empty   = (level == '0);
   assign full    = (level == CNT_W'(DEPTH));
   assign do_push = push & ~full;
   assign do_pop  = pop & ~empty;
   assign head    = mem[rd_ptr];

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
         ovf    <= 1'b0;
      end else if (!mrst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
         ovf    <= 1'b0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         case ({do_push, do_pop})
            2'b10:   level <= level + 1'b1;
            2'b01:   level <= level - 1'b1;
            default: level <= level;
         endcase
         if (push && full) ovf <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= push_data;
   end
endmodule

// File: rtl/a429_repeat_if.sv
// Top: received-word host reader with repeater path into the transmit FIFO.
module a429_repeat_if #(
   parameter int unsigned WORD_W   = 32,
   parameter int unsigned BUS_W    = 16,
   parameter int unsigned TX_DEPTH = 8,
   parameter bit          ODD_PAR  = 1'b1
) (
   input  logic                            clk,
   input  logic                            por_n,
   input  logic                            mrst_n,
   input  logic                            rx_valid,
   input  logic [WORD_W-1:0]               rx_word,
   output logic                            rx_ready,
   output logic                            dready_n,
   input  logic                            half_sel,
   input  logic                            rd_en_n,
   output logic [BUS_W-1:0]                host_dout,
   input  logic                            cw_wr_n,
   input  logic [1:0]                      ctrl_din,
   output logic                            ctrl_rpt,
   output logic                            ctrl_par,
   input  logic                            tx_pop,
   output logic [WORD_W-1:0]               tx_head,
   output logic                            tx_empty,
   output logic                            tx_full,
   output logic [$clog2(TX_DEPTH+1)-1:0]   tx_level,
   output logic                            seq_err,
   output logic                            tx_ovf
);
   import a429_rpt_pkg::*;

   generate
      if (WORD_W != 2 * BUS_W) begin : g_bad_width
         $error("WORD_W must be twice BUS_W");
      end
      if (TX_DEPTH < 2) begin : g_bad_depth
         $error("TX_DEPTH must be at least 2");
      end
   endgenerate

   ctrl_t             ctrl_q;
   logic              rd_stb, cw_stb;
   logic              held, rd_ok, word_load, push;
   logic [WORD_W-1:0] hold_word, push_word;

   a429_fall_strobe u_rd_edge (
      .clk    (clk),
      .por_n  (por_n),
      .lvl_n  (rd_en_n),
      .strobe (rd_stb)
   );

   a429_fall_strobe u_cw_edge (
      .clk    (clk),
      .por_n  (por_n),
      .lvl_n  (cw_wr_n),
      .strobe (cw_stb)
   );

   // Control register: only power-on reset clears it.
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)      ctrl_q <= '0;
      else if (cw_stb) ctrl_q <= ctrl_din;
   end

   assign ctrl_rpt = ctrl_q.rpt_en;
   assign ctrl_par = ctrl_q.par_en;

   a429_rx_hold #(.WORD_W(WORD_W), .BUS_W(BUS_W)) u_hold (
      .clk       (clk),
      .por_n     (por_n),
      .mrst_n    (mrst_n),
      .rx_valid  (rx_valid),
      .rx_word   (rx_word),
      .rx_ready  (rx_ready),
      .rd_stb    (rd_stb),
      .rd_en_n   (rd_en_n),
      .half_sel  (half_sel),
      .host_dout (host_dout),
      .held      (held),
      .rd_ok     (rd_ok),
      .word_load (word_load),
      .hold_word (hold_word)
   );

   assign dready_n = ~held;

   a429_repeat_seq #(.WORD_W(WORD_W), .BUS_W(BUS_W), .ODD_PAR(ODD_PAR)) u_seq (
      .clk       (clk),
      .por_n     (por_n),
      .mrst_n    (mrst_n),
      .rpt_en    (ctrl_q.rpt_en),
      .par_en    (ctrl_q.par_en),
      .rd_ok     (rd_ok),
      .half_sel  (half_sel),
      .word_load (word_load),
      .hold_word (hold_word),
      .push      (push),
      .push_word (push_word),
      .seq_err   (seq_err)
   );

   a429_tx_fifo #(.WORD_W(WORD_W), .DEPTH(TX_DEPTH)) u_fifo (
      .clk       (clk),
      .por_n     (por_n),
      .mrst_n    (mrst_n),
      .push      (push),
      .push_data (push_word),
      .pop       (tx_pop),
      .head      (tx_head),
      .empty     (tx_empty),
      .full      (tx_full),
      .level     (tx_level),
      .ovf       (tx_ovf)
   );
endmodule

// File: rtl/a429_repeat_if_chk.sv
module a429_repeat_if_chk #(
   parameter int unsigned TX_DEPTH = 8,
   localparam int unsigned CNT_W   = $clog2(TX_DEPTH + 1)
) (
   input logic             clk,
   input logic             por_n,
   input logic             mrst_n,
   input logic             rx_valid,
   input logic             rx_ready,
   input logic             dready_n,
   input logic             cw_wr_n,
   input logic             ctrl_rpt,
   input logic             ctrl_par,
   input logic             tx_pop,
   input logic [CNT_W-1:0] tx_level,
   input logic             tx_full,
   input logic             tx_empty,
   input logic             seq_err,
   input logic             tx_ovf
);
   // R2
   load_flag_chk: assert property (@(posedge clk) disable iff (!por_n)
      rx_valid && rx_ready |=> !dready_n);

   // R4
   normal_no_push_chk: assert property (@(posedge clk) disable iff (!por_n)
      mrst_n && !ctrl_rpt |=> tx_level <= $past(tx_level));

   // R7
   seq_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
      mrst_n && seq_err |=> seq_err);

   // R8
   level_bound_chk: assert property (@(posedge clk) disable iff (!por_n)
      tx_level <= CNT_W'(TX_DEPTH));

   // R9
   full_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
      mrst_n && tx_full && !tx_pop |=> tx_full && tx_level == $past(tx_level));

   // R10
   mreset_clear_chk: assert property (@(posedge clk) disable iff (!por_n)
      !mrst_n |=> tx_empty && dready_n && !seq_err && !tx_ovf);

   // R10
   mreset_ctrl_chk: assert property (@(posedge clk) disable iff (!por_n)
      !mrst_n && cw_wr_n |=> ctrl_rpt == $past(ctrl_rpt) && ctrl_par == $past(ctrl_par));
endmodule

bind a429_repeat_if a429_repeat_if_chk #(.TX_DEPTH(TX_DEPTH)) u_chk (
   .clk      (clk),
   .por_n    (por_n),
   .mrst_n   (mrst_n),
   .rx_valid (rx_valid),
   .rx_ready (rx_ready),
   .dready_n (dready_n),
   .cw_wr_n  (cw_wr_n),
   .ctrl_rpt (ctrl_rpt),
   .ctrl_par (ctrl_par),
   .tx_pop   (tx_pop),
   .tx_level (tx_level),
   .tx_full  (tx_full),
   .tx_empty (tx_empty),
   .seq_err  (seq_err),
   .tx_ovf   (tx_ovf)
);

// File: tb/sim_a429_repeat_if.sv
`timescale 1ns/1ps
module sim_a429_repeat_if;
   logic        clk = 1'b0;
   logic        por_n, mrst_n, rx_valid, half_sel, rd_en_n, cw_wr_n, tx_pop;
   logic [31:0] rx_word, tx_head;
   logic [1:0]  ctrl_din;
   logic        rx_ready, dready_n, ctrl_rpt, ctrl_par, tx_empty, tx_full, seq_err, tx_ovf;
   logic [15:0] host_dout;
   logic [3:0]  tx_level;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   a429_repeat_if u0 (
      .clk(clk), .por_n(por_n), .mrst_n(mrst_n), .rx_valid(rx_valid), .rx_word(rx_word),
      .rx_ready(rx_ready), .dready_n(dready_n), .half_sel(half_sel), .rd_en_n(rd_en_n),
      .host_dout(host_dout), .cw_wr_n(cw_wr_n), .ctrl_din(ctrl_din), .ctrl_rpt(ctrl_rpt),
      .ctrl_par(ctrl_par), .tx_pop(tx_pop), .tx_head(tx_head), .tx_empty(tx_empty),
      .tx_full(tx_full), .tx_level(tx_level), .seq_err(seq_err), .tx_ovf(tx_ovf)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] gen(input int i);
      if (i == 14) return 32'hFFFF_FFFF;
      if (i == 15) return 32'h0000_0000;
      return (32'h9E37_79B9 * 32'(i + 1)) ^ {8'(i * 37), 24'h5A_1C3};
   endfunction

   function automatic logic [31:0] fill_par(input logic [31:0] w, input logic p);
      if (!p) return w;
      return {~(^w[30:0]), w[30:0]};
   endfunction

   task automatic load_word(input logic [31:0] w);
      @(negedge clk); rx_valid = 1'b1; rx_word = w;
      @(negedge clk); rx_valid = 1'b0;
   endtask

   task automatic read_half(input logic s, output logic [15:0] d);
      @(negedge clk); half_sel = s; rd_en_n = 1'b0;
      #1 d = host_dout;
      @(negedge clk); rd_en_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic write_ctrl(input logic [1:0] v);
      @(negedge clk); ctrl_din = v; cw_wr_n = 1'b0;
      @(negedge clk); cw_wr_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic pop_one();
      @(negedge clk); tx_pop = 1'b1;
      @(negedge clk); tx_pop = 1'b0;
   endtask

   task automatic master_reset();
      @(negedge clk); mrst_n = 1'b0;
      @(negedge clk); mrst_n = 1'b1;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         tests++; fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      logic [15:0] d;
      logic [31:0] w, exp;
      logic        rpt, par, first;
      por_n = 1'b0; mrst_n = 1'b1; rx_valid = 1'b0; rx_word = '0; half_sel = 1'b0;
      rd_en_n = 1'b1; cw_wr_n = 1'b1; ctrl_din = '0; tx_pop = 1'b0;
      repeat (3) @(negedge clk);
      por_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 dready_n", 32'(dready_n), 32'd1);
      check("R1 rx_ready", 32'(rx_ready), 32'd1);
      check("R1 tx_empty", 32'(tx_empty), 32'd1);
      check("R1 tx_level", 32'(tx_level), 32'd0);
      check("R1 flags", {seq_err, tx_ovf, ctrl_rpt, ctrl_par}, 32'd0);
      check("R3 idle bus", 32'(host_dout), 32'd0);

      // Sweep: words x {rpt,par} x read order
      for (int i = 0; i < 16; i++) begin
         for (int m = 0; m < 4; m++) begin
            for (int o = 0; o < 2; o++) begin
               w = gen(i); rpt = m[0]; par = m[1]; first = o[0];
               write_ctrl({par, rpt});
               check("R11 ctrl_rpt", 32'(ctrl_rpt), 32'(rpt));
               check("R11 ctrl_par", 32'(ctrl_par), 32'(par));
               load_word(w);
               check("R2 dready_n low", 32'(dready_n), 32'd0);
               check("R2 rx_ready low", 32'(rx_ready), 32'd0);
               read_half(first, d);
               check("R3 first half", 32'(d), first ? 32'(w[31:16]) : 32'(w[15:0]));
               check("R4 still ready", 32'(dready_n), 32'd0);
               read_half(~first, d);
               check("R3 second half", 32'(d), first ? 32'(w[15:0]) : 32'(w[31:16]));
               check("R4 ready released", 32'(dready_n), 32'd1);
               if (rpt && !first) begin
                  exp = fill_par(w, par);
                  check("R5 one queued", 32'(tx_level), 32'd1);
                  check(par ? "R6 parity word" : "R5 repeated word", tx_head, exp);
                  pop_one();
                  check("R8 empty after pop", 32'(tx_empty), 32'd1);
               end else begin
                  check(rpt ? "R7 nothing queued" : "R4 normal no queue", 32'(tx_level), 32'd0);
               end
               check("R7 seq_err", 32'(seq_err), 32'(rpt && first));
               if (rpt && first) begin
                  master_reset();
                  check("R10 seq_err cleared", 32'(seq_err), 32'd0);
                  check("R10 ctrl kept", {ctrl_par, ctrl_rpt}, 32'({par, rpt}));
               end
            end
         end
      end

      // R12: strobe with no word held
      write_ctrl(2'b01);
      read_half(1'b1, d);
      read_half(1'b0, d);
      read_half(1'b1, d);
      check("R12 no queue", 32'(tx_level), 32'd0);
      check("R12 no seq_err", 32'(seq_err), 32'd0);
      check("R12 dready_n", 32'(dready_n), 32'd1);

      // R8/R9: fill and overflow
      for (int k = 0; k < 9; k++) begin
         load_word(gen(k) ^ 32'h0F0F_0000);
         read_half(1'b0, d);
         read_half(1'b1, d);
         if (k == 7) begin
            check("R8 full", 32'(tx_full), 32'd1);
            check("R8 level 8", 32'(tx_level), 32'd8);
            check("R9 no ovf yet", 32'(tx_ovf), 32'd0);
         end
      end
      check("R9 level kept", 32'(tx_level), 32'd8);
      check("R9 ovf set", 32'(tx_ovf), 32'd1);
      for (int k = 0; k < 8; k++) begin
         check("R8 order", tx_head, gen(k) ^ 32'h0F0F_0000);
         pop_one();
      end
      check("R8 drained", 32'(tx_empty), 32'd1);
      check("R9 ovf sticky", 32'(tx_ovf), 32'd1);
      pop_one();
      check("R8 pop on empty", 32'(tx_level), 32'd0);

      // R10: master reset with a word held and words queued
      write_ctrl(2'b11);
      for (int k = 0; k < 3; k++) begin
         load_word(gen(k + 3));
         read_half(1'b0, d);
         read_half(1'b1, d);
      end
      load_word(32'hCAFE_1234);
      check("R10 pre level", 32'(tx_level), 32'd3);
      check("R10 pre held", 32'(dready_n), 32'd0);
      master_reset();
      check("R10 empty", 32'(tx_empty), 32'd1);
      check("R10 dready_n", 32'(dready_n), 32'd1);
      check("R10 ovf cleared", 32'(tx_ovf), 32'd0);
      check("R10 ctrl kept", {ctrl_par, ctrl_rpt}, 32'd3);
      load_word(32'h8000_0001);
      read_half(1'b0, d);
      read_half(1'b1, d);
      check("R6 parity after reset", tx_head, fill_par(32'h8000_0001, 1'b1));

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule